// File: doc/BRIEF.md
# Watchdog Service Request Synchronizer

This block holds a small bus-side register of service bits, one for each watchdog subcounter. The subcounters run on a slow low-frequency clock. Firmware writes a one to a bit on the fast bus clock to ask that the matching subcounter be restarted from zero. The request travels into the slow domain as a toggle, restarts the subcounter there, and an acknowledge toggle travels back. Only when the acknowledge arrives does hardware drop the bit. Firmware can therefore poll the bit: while it reads one, the service is still in flight.

A nonzero lock field blocks every write. A subcounter whose enable is low still completes the handshake, but its count is left alone. This keeps a value loaded while the counter was stopped, and no lower-action event is raised. An enabled subcounter that is serviced raises a lower-action pulse lasting one slow cycle, in the same cycle that its count reads zero.

Top module: `wdt_service_sync`

## Requirements
- R1: Writing 1 to bit 0 or bit 1 of `wr_data` with `wr_en` high and `lock` zero sets the matching pending bit. The pending bit reads back at the same bit position of `rd_data` from the next bus cycle on. Bit 0 belongs to subcounter 0 and bit 1 to subcounter 1.
- R2: Writing 0 to a service bit has no effect. Bits 31:2 of `rd_data` always read 0, and writes to those bits have no effect.
- R3: While `lock` is nonzero, a write changes no pending bit and starts no service.
- R4: An enabled subcounter is cleared to zero by the third rising slow-clock edge after the bus edge that accepted the write.
- R5: A pending bit stays 1 until the acknowledge has come back from the slow domain. Hardware then clears it to 0 without any further write.
- R6: A write of 1 to a bit that is already pending is absorbed. It causes exactly one clear and one lower-action pulse in total.
- R7: Servicing a disabled subcounter keeps its count, including a preloaded value, and raises no lower-action pulse. Its pending bit still clears.
- R8: Each service of an enabled subcounter raises `lower_evt` for exactly one slow cycle, and the count reads 0 during that cycle.
- R9: After reset, `rd_data`, all counts and `lower_evt` are 0.
- R10: An enabled subcounter increases by one per slow cycle. A high `ctr_load` loads `load_val` in the next slow cycle, whether or not the subcounter is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| wr_en | input | 1 | Write strobe for the service register |
| wr_data | input | DW | Write data; one bit per subcounter at the low end |
| lock | input | LW | Lock field; any nonzero value blocks writes |
| rd_data | output | DW | Read value: pending bits, zero above them |
| slow_clk | input | 1 | Slow low-frequency clock |
| slow_rst_n | input | 1 | Asynchronous active-low reset, slow domain |
| ctr_en | input | NCTR | Per-subcounter enable (slow domain) |
| ctr_load | input | NCTR | Per-subcounter preload strobe (slow domain) |
| load_val | input | CW | Value used by a preload |
| count | output | NCTR*CW | Subcounter values; subcounter i at bits i*CW +: CW |
| lower_evt | output | NCTR | One-slow-cycle lower-action pulse per subcounter |

## Verification
The hardest case to reach is a second write that arrives while the first request is still moving through the two synchronizers. Only then can an absorbed write be told apart from a double service. The bench issues the second write on the very next bus cycle after the first, and then counts lower-action pulses until the bit drops. A related case is a disabled subcounter that holds a preloaded value. To reach it, the bench applies a preload strobe on the slow side before servicing that subcounter, then checks that the loaded value survives the whole handshake.

// File: rtl/wdt_svc_pkg.sv
package wdt_svc_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_CLEAR = 2'd2,
    ACT_COUNT = 2'd3
  } ctr_act_e;

  // Preload wins; a disabled counter holds; a service clears; otherwise count.
  function automatic ctr_act_e pick_action(input logic load,
                                           input logic en,
                                           input logic svc);
    if (load)      return ACT_LOAD;
    else if (!en)  return ACT_HOLD;
    else if (svc)  return ACT_CLEAR;
    else           return ACT_COUNT;
  endfunction

  // A request is accepted only when every lock bit is clear.
  function automatic logic write_open(input logic wr, input logic lock_any);
    return wr && !lock_any;
  endfunction

  // Start a handshake only for a bit that is requested and not yet pending.
  function automatic logic start_req(input logic open,
                                     input logic bit_in,
                                     input logic pending);
    return open && bit_in && !pending;
  endfunction

endpackage

// File: rtl/svc_sync.sv
module svc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/svc_bus_side.sv
module svc_bus_side
  import wdt_svc_pkg::*;
#(
  parameter int NCTR   = 2,
  parameter int LW     = 2,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NCTR-1:0] wr_bits,
  input  logic [LW-1:0]   lock,
  input  logic [NCTR-1:0] ack_tgl,
  output logic [NCTR-1:0] req_tgl,
  output logic [NCTR-1:0] pend
);
  logic [NCTR-1:0] ack_s;
  logic            wr_open;

  assign wr_open = write_open(wr_en, |lock);

  for (genvar i = 0; i < NCTR; i++) begin : g_bit
    svc_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (ack_tgl[i]),
      .q    (ack_s[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        req_tgl[i] <= 1'b0;
      else if (start_req(wr_open, wr_bits[i], pend[i]))
        req_tgl[i] <= ~req_tgl[i];
    end

    // A bit is pending while the returned toggle lags the issued one.
    assign pend[i] = req_tgl[i] ^ ack_s[i];
  end
endmodule

// File: rtl/svc_subctr.sv
module svc_subctr
  import wdt_svc_pkg::*;
#(
  parameter int CW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_tgl,
  input  logic          en,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          evt,
  output logic          svc_pulse,
  output logic          ack_tgl
);
  logic     req_s;
  logic     req_d;
  ctr_act_e act;

  svc_sync #(.STAGES(STAGES)) u_req_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (req_tgl),
    .q    (req_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_d <= 1'b0;
    else        req_d <= req_s;
  end

  assign svc_pulse = req_s ^ req_d;
  assign ack_tgl   = req_d;
  assign act       = pick_action(load, en, svc_pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      evt   <= 1'b0;
    end else begin
      evt <= (act == ACT_CLEAR);
      unique case (act)
        ACT_LOAD:  count <= load_val;
        ACT_CLEAR: count <= '0;
        ACT_COUNT: count <= count + CW'(1);
        default:   count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wdt_service_sync.sv
module wdt_service_sync #(
  parameter int NCTR   = 2,
  parameter int CW     = 16,
  parameter int DW     = 32,
  parameter int LW     = 2,
  parameter int STAGES = 2
) (
  input  logic             bus_clk,
  input  logic             bus_rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic [LW-1:0]    lock,
  output logic [DW-1:0]    rd_data,
  input  logic             slow_clk,
  input  logic             slow_rst_n,
  input  logic [NCTR-1:0]  ctr_en,
  input  logic [NCTR-1:0]  ctr_load,
  input  logic [CW-1:0]    load_val,
  output logic [NCTR*CW-1:0] count,
  output logic [NCTR-1:0]  lower_evt
);
  logic [NCTR-1:0] req_tgl;
  logic [NCTR-1:0] ack_tgl;
  logic [NCTR-1:0] pend;
  logic [NCTR-1:0] svc_pulse;
  logic            unused_hi;

  assign unused_hi = &{1'b0, wr_data[DW-1:NCTR]};

  svc_bus_side #(.NCTR(NCTR), .LW(LW), .STAGES(STAGES)) u_bus (
    .clk    (bus_clk),
    .rst_n  (bus_rst_n),
    .wr_en  (wr_en),
    .wr_bits(wr_data[NCTR-1:0]),
    .lock   (lock),
    .ack_tgl(ack_tgl),
    .req_tgl(req_tgl),
    .pend   (pend)
  );

  assign rd_data = DW'(pend);

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    svc_subctr #(.CW(CW), .STAGES(STAGES)) u_ctr (
      .clk      (slow_clk),
      .rst_n    (slow_rst_n),
      .req_tgl  (req_tgl[i]),
      .en       (ctr_en[i]),
      .load     (ctr_load[i]),
      .load_val (load_val),
      .count    (count[i*CW +: CW]),
      .evt      (lower_evt[i]),
      .svc_pulse(svc_pulse[i]),
      .ack_tgl  (ack_tgl[i])
    );
  end
endmodule

// File: rtl/wdt_service_sync_chk.sv
module wdt_service_sync_chk #(
  parameter int NCTR = 2,
  parameter int CW   = 16,
  parameter int DW   = 32,
  parameter int LW   = 2
) (
  input logic               bus_clk,
  input logic               bus_rst_n,
  input logic               wr_en,
  input logic [DW-1:0]      wr_data,
  input logic [LW-1:0]      lock,
  input logic [DW-1:0]      rd_data,
  input logic               slow_clk,
  input logic               slow_rst_n,
  input logic [NCTR-1:0]    ctr_en,
  input logic [NCTR-1:0]    ctr_load,
  input logic [NCTR*CW-1:0] count,
  input logic [NCTR-1:0]    lower_evt,
  input logic [NCTR-1:0]    svc_pulse
);
  for (genvar i = 0; i < NCTR; i++) begin : g_p
    // R3: a locked write cannot raise an idle bit
    assert_lock_ignores_R3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (wr_en && lock != '0 && !rd_data[i]) |=> !rd_data[i]);

    // R1: a pending bit only rises after an accepted write of one
    assert_pend_needs_write_R1: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      $rose(rd_data[i]) |-> ($past(wr_en) && $past(lock) == '0 && $past(wr_data[i])));

    // R4 / R8: a service of an enabled counter zeroes it and pulses the event
    assert_clear_enabled_R8: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
      (svc_pulse[i] && ctr_en[i] && !ctr_load[i]) |=>
        (count[i*CW +: CW] == '0 && lower_evt[i]));

    // R7: a disabled counter never raises the event
    assert_disabled_noevt_R7: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
      (!ctr_en[i] && !ctr_load[i]) |=> !lower_evt[i]);

    // R7: a disabled counter without load keeps its value
    assert_disabled_hold_R7: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
      (!ctr_en[i] && !ctr_load[i]) |=> $stable(count[i*CW +: CW]));

    // R8: the event lasts one slow cycle
    assert_evt_single_R8: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
      lower_evt[i] |=> !lower_evt[i]);
  end
endmodule

bind wdt_service_sync wdt_service_sync_chk #(
  .NCTR(NCTR), .CW(CW), .DW(DW), .LW(LW)
) u_chk (
  .bus_clk   (bus_clk),
  .bus_rst_n (bus_rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .lock      (lock),
  .rd_data   (rd_data),
  .slow_clk  (slow_clk),
  .slow_rst_n(slow_rst_n),
  .ctr_en    (ctr_en),
  .ctr_load  (ctr_load),
  .count     (count),
  .lower_evt (lower_evt),
  .svc_pulse (svc_pulse)
);

// File: tb/wdt_service_sync_test.sv
module wdt_service_sync_test;
  logic        bus_clk = 0, slow_clk = 0;
  logic        bus_rst_n = 0, slow_rst_n = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [1:0]  lock = '0;
  logic [31:0] rd_data;
  logic [1:0]  ctr_en = 2'b11, ctr_load = 2'b00;
  logic [15:0] load_val = '0;
  logic [31:0] count;
  logic [1:0]  lower_evt;

  int errors = 0, checks = 0;
  int ev0 = 0, ev1 = 0, slow_pos = 0, t0 = 0;
  bit done = 0;

  wdt_service_sync uut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .lock(lock), .rd_data(rd_data), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
    .ctr_en(ctr_en), .ctr_load(ctr_load), .load_val(load_val), .count(count),
    .lower_evt(lower_evt)
  );

  always #10 bus_clk = ~bus_clk;
  initial begin #37; forever begin slow_clk = 1; #50; slow_clk = 0; #50; end end
  always @(posedge slow_clk) slow_pos++;
  always @(negedge slow_clk) begin
    if (lower_evt[0]) ev0++;
    if (lower_evt[1]) ev1++;
  end

  // fields: lock[35:34], data[33:2], expected pending[1:0]
  localparam logic [35:0] VEC [7] = '{
    {2'd0, 32'h0000_0001, 2'b01},
    {2'd0, 32'h0000_0002, 2'b10},
    {2'd0, 32'h0000_0003, 2'b11},
    {2'd0, 32'h0000_0000, 2'b00},
    {2'd1, 32'h0000_0003, 2'b00},
    {2'd0, 32'hFFFF_FFFC, 2'b00},
    {2'd2, 32'h0000_0001, 2'b00}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] lk, input logic [31:0] d);
    @(negedge bus_clk);
    lock = lk; wr_data = d; wr_en = 1;
    @(posedge bus_clk);
    t0 = slow_pos;
    #1 wr_en = 0; lock = '0; wr_data = '0;
  endtask

  task automatic wait_idle(output bit cleared);
    cleared = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge bus_clk);
      if (rd_data[1:0] == 2'b00) begin cleared = 1; break; end
    end
    repeat (2) @(negedge slow_clk);
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit clr;
    int b0, b1;
    logic [15:0] c_a;
    repeat (3) @(negedge bus_clk);
    // R9: reset state while resets are held
    check(rd_data == 0, "R9 rd_data", rd_data, 0);
    check(count == 0, "R9 count", count, 0);
    check(lower_evt == 0, "R9 lower_evt", {30'd0, lower_evt}, 0);
    bus_rst_n = 1; slow_rst_n = 1;
    repeat (3) @(negedge slow_clk);

    // R10: enabled counter steps by one per slow cycle
    @(negedge slow_clk); c_a = count[15:0];
    @(negedge slow_clk);
    check(count[15:0] == c_a + 16'd1, "R10 increment", {16'd0, count[15:0]}, {16'd0, c_a + 16'd1});

    // Vector table: R1, R2, R3, R4, R5
    foreach (VEC[v]) begin
      b0 = ev0; b1 = ev1;
      bus_write(VEC[v][35:34], VEC[v][33:2]);
      @(negedge bus_clk);
      check(rd_data[1:0] == VEC[v][1:0], "R1/R2/R3 pending", rd_data, {30'd0, VEC[v][1:0]});
      check(rd_data[31:2] == 0, "R2 reserved", rd_data, {30'd0, rd_data[1:0]});
      wait_idle(clr);
      check(clr, "R5 hardware clear", {31'd0, clr}, 1);
      check((ev0 - b0) == int'(VEC[v][0]) && (ev1 - b1) == int'(VEC[v][1]),
            "R3/R4 service events", (ev1 - b1) * 2 + (ev0 - b0), {30'd0, VEC[v][1:0]});
    end

    // R4 / R8: latency within three slow edges, count zero during pulse
    bus_write(2'd0, 32'h1);
    for (int k = 0; k < 10; k++) begin
      @(negedge slow_clk);
      if (lower_evt[0]) break;
    end
    check(lower_evt[0] && (slow_pos - t0) <= 3, "R4 latency", slow_pos - t0, 3);
    check(count[15:0] == 0, "R8 zero with pulse", {16'd0, count[15:0]}, 0);
    @(negedge slow_clk);
    check(!lower_evt[0], "R8 single-cycle pulse", {31'd0, lower_evt[0]}, 0);
    wait_idle(clr);

    // R6: second write while pending is absorbed
    b0 = ev0;
    bus_write(2'd0, 32'h1);
    bus_write(2'd0, 32'h1);
    @(negedge bus_clk);
    check(rd_data[0], "R6 still pending", rd_data, 1);
    wait_idle(clr);
    repeat (4) @(negedge slow_clk);
    check(clr && (ev0 - b0) == 1, "R6 one event", ev0 - b0, 1);

    // R10: load on an enabled counter
    @(negedge slow_clk); load_val = 16'h1234; ctr_load = 2'b01;
    @(negedge slow_clk); ctr_load = 2'b00;
    check(count[15:0] == 16'h1234, "R10 load", {16'd0, count[15:0]}, 32'h1234);

    // R7: disabled counter keeps preload, no event, pending still clears
    ctr_en = 2'b01;
    @(negedge slow_clk); load_val = 16'h0055; ctr_load = 2'b10;
    @(negedge slow_clk); ctr_load = 2'b00;
    b1 = ev1;
    bus_write(2'd0, 32'h2);
    @(negedge bus_clk);
    check(rd_data[1], "R7 pending set", rd_data, 2);
    wait_idle(clr);
    check(clr, "R7 pending clears", {31'd0, clr}, 1);
    check(count[31:16] == 16'h0055, "R7 preload kept", {16'd0, count[31:16]}, 32'h55);
    check(ev1 == b1, "R7 no event", ev1 - b1, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule